// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the configuration state for two downstream memory windows of a bus bridge and decodes every incoming 32-bit memory address against them. Each window has a base register and a limit register, both reached through a small configuration port that addresses registers by byte offset and writes them under byte enables. Windows are placed on 4 KB pages. The low twelve bits of every base and limit register are tied to zero.

For the address on `mem_addr`, the decoder reports whether one of the windows claims it, which window that is, and whether that window is marked prefetchable. The prefetch marks are two bits of a bridge control register. The decode path is purely combinational. Configuration reads return data one cycle after the read strobe.

Top module: `mwin_decoder`

## Requirements
- R1: After synchronous reset every base, limit and control bit is zero, `cfg_rdata` is zero and no address is claimed.
- R2: Base registers sit at offsets 1Ch (window 0) and 24h (window 1), and limit registers sit at 20h (window 0) and 28h (window 1). Bits 31:12 of each are writable, and a write changes only the bytes whose `cfg_be` bit is set (bit n covers data bits 8n+7:8n).
- R3: Bits 11:0 of every base and limit register read back as zero, whatever was written to them.
- R4: A window whose base and limit are both zero claims nothing. After reset, addresses 0 to FFFh are not claimed.
- R5: An enabled window claims an address A when base <= A <= {limit[31:12], FFFh}. The page named by the limit is included, and a window with limit below base claims nothing.
- R6: When both windows claim the same address, `win_claim` is 1 and `win_idx` is 0.
- R7: The control register sits at offset 3Ch. Its bit 8 marks window 0 prefetchable and its bit 9 marks window 1 prefetchable, and both are written under `cfg_be[1]`. `win_prefetch` is the mark of the claiming window, and 0 when nothing is claimed.
- R8: Reads from any offset other than the four window registers and 3Ch return zero, and control bits other than 9:8 read as zero. Writes to such offsets change no register.
- R9: A write accepted at a clock edge changes the decode from just after that edge. A read issued in the same cycle as a write to the same offset returns the value from before the write. `cfg_rdata` is loaded at the edge that samples `cfg_rd` and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_rdata | output | 32 | Registered read data |
| mem_addr | input | 32 | Memory address to decode |
| win_claim | output | 1 | Address lies in an enabled window |
| win_idx | output | 1 | Index of the claiming window |
| win_prefetch | output | 1 | Claiming window is prefetchable |

## Verification
A configuration write and a decode can fall in the same cycle, and so can a write and a read of the same register. The bench drives a base write, a read of that offset and an address inside the old window all in one cycle. Before the edge it expects the old claim. After the edge it expects the old read data and a decode that matches the new base. Address sweeps over page starts and page ends, run against a model in the bench, cover overlap priority, inclusive limit pages, inverted windows and the top of the address space.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_PAGE_BITS = 12;
  localparam int unsigned DEF_CFG_AW    = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mwin_regs.sv
module mwin_regs
  import mwin_pkg::*;
#(
  parameter int unsigned NUM_WIN    = 2,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned PAGE_BITS  = DEF_PAGE_BITS,
  parameter int unsigned CFG_AW     = DEF_CFG_AW,
  parameter int unsigned BASE_OFF   = 'h1C,
  parameter int unsigned WIN_STRIDE = 8,
  parameter int unsigned LIMIT_GAP  = 4,
  parameter int unsigned CTL_OFF    = 'h3C,
  parameter int unsigned PF_LSB     = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_wr,
  input  logic                             cfg_rd,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [ADDR_W-1:0]                cfg_wdata,
  input  logic [ADDR_W/8-1:0]              cfg_be,
  output logic [ADDR_W-1:0]                cfg_rdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   limit_o,
  output logic [NUM_WIN-1:0]               pf_o
);
  localparam int unsigned BE_W = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] WMASK =
    {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q, limit_q;
  logic [NUM_WIN-1:0]             pf_q;
  logic [NUM_WIN-1:0]             sel_base, sel_lim;
  logic                           sel_ctl, sel_any;
  logic [ADDR_W-1:0]              rd_mux;

  function automatic logic [ADDR_W-1:0] merge_bytes(
    input logic [ADDR_W-1:0] old_v,
    input logic [ADDR_W-1:0] new_v,
    input logic [BE_W-1:0]   be
  );
    logic [ADDR_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r & WMASK;
  endfunction

  // Offset decode, one comparator pair per window
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_sel
    assign sel_base[i] = (cfg_addr == CFG_AW'(BASE_OFF + i*WIN_STRIDE));
    assign sel_lim[i]  = (cfg_addr == CFG_AW'(BASE_OFF + i*WIN_STRIDE + LIMIT_GAP));
  end
  assign sel_ctl = (cfg_addr == CFG_AW'(CTL_OFF));
  assign sel_any = (|sel_base) || (|sel_lim) || sel_ctl;

  // Register storage
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
      pf_q    <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (sel_base[i]) base_q[i]  <= merge_bytes(base_q[i],  cfg_wdata, cfg_be);
        if (sel_lim[i])  limit_q[i] <= merge_bytes(limit_q[i], cfg_wdata, cfg_be);
        if (sel_ctl && cfg_be[(PF_LSB+i)/8]) pf_q[i] <= cfg_wdata[PF_LSB+i];
      end
    end
  end

  // Read-back mux
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel_base[i]) rd_mux = rd_mux | (base_q[i]  & WMASK);
      if (sel_lim[i])  rd_mux = rd_mux | (limit_q[i] & WMASK);
      if (sel_ctl)     rd_mux[PF_LSB+i] = pf_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
  assign pf_o    = pf_q;

  // R1: read data is cleared by reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (cfg_rdata == '0));

  // R3: window register reads never return low bits
  p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !sel_ctl) |=> (cfg_rdata[PAGE_BITS-1:0] == '0));

  // R8: unmapped offsets read zero
  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !sel_any) |=> (cfg_rdata == '0));

  // R9: read data holds between reads
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rd && !$past(rst)) |=> $stable(cfg_rdata));
endmodule

// File: rtl/mwin_match.sv
module mwin_match #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LOW_FILL =
    {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic enabled, at_or_above, at_or_below;

  assign enabled     = (base_i != '0) || (limit_i != '0);
  assign at_or_above = (addr_i >= base_i);
  assign at_or_below = (addr_i <= (limit_i | LOW_FILL));
  assign hit_o       = enabled && at_or_above && at_or_below;
endmodule

// File: rtl/mwin_decoder.sv
module mwin_decoder
  import mwin_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
  parameter int unsigned CFG_AW    = DEF_CFG_AW,
  localparam int unsigned IDX_W    = idx_width(NUM_WIN),
  localparam int unsigned BE_W     = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [BE_W-1:0]   cfg_be,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              win_claim,
  output logic [IDX_W-1:0]  win_idx,
  output logic              win_prefetch
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_w, limit_w;
  logic [NUM_WIN-1:0]             pf_w;
  logic [NUM_WIN-1:0]             hit;

  mwin_regs #(
    .NUM_WIN  (NUM_WIN),
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .CFG_AW   (CFG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_be   (cfg_be),
    .cfg_rdata(cfg_rdata),
    .base_o   (base_w),
    .limit_o  (limit_w),
    .pf_o     (pf_w)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    mwin_match #(
      .ADDR_W   (ADDR_W),
      .PAGE_BITS(PAGE_BITS)
    ) u_match (
      .base_i (base_w[i]),
      .limit_i(limit_w[i]),
      .addr_i (mem_addr),
      .hit_o  (hit[i])
    );
  end

  // Lowest-numbered hit wins
  always_comb begin
    win_claim    = |hit;
    win_idx      = '0;
    win_prefetch = 1'b0;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (hit[i]) begin
        win_idx      = IDX_W'(i);
        win_prefetch = pf_w[i];
      end
    end
  end

  // R4: a claim requires the chosen window to be enabled
  p_enable_r4: assert property (@(posedge clk) disable iff (rst)
    win_claim |-> ((base_w[win_idx] != '0) || (limit_w[win_idx] != '0)));

  // R6: window 0 wins an overlap
  p_prio_r6: assert property (@(posedge clk) disable iff (rst)
    hit[0] |-> (win_claim && (win_idx == '0)));

  // R7: no prefetch mark without a claim
  p_pf_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !win_claim |-> !win_prefetch);

  // R7: the mark follows the chosen window
  p_pf_src_r7: assert property (@(posedge clk) disable iff (rst)
    win_claim |-> (win_prefetch == pf_w[win_idx]));
endmodule

// File: tb/tb_mwin_decoder.sv
module tb_mwin_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_rdata;
  logic [31:0] mem_addr;
  logic        win_claim;
  logic [0:0]  win_idx;
  logic        win_prefetch;

  always #4 clk = ~clk;   // 125 MHz

  mwin_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rdata(cfg_rdata), .mem_addr(mem_addr), .win_claim(win_claim),
    .win_idx(win_idx), .win_prefetch(win_prefetch)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_base [2];
  logic [31:0] m_lim  [2];
  logic [1:0]  m_pf;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d,
                                      input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r & 32'hFFFF_F000;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    for (int i = 0; i < 2; i++) begin
      if (a == 8'(8'h1C + 8*i)) return m_base[i];
      if (a == 8'(8'h20 + 8*i)) return m_lim[i];
    end
    if (a == 8'h3C) return {22'd0, m_pf, 8'd0};
    return 32'd0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (a == 8'(8'h1C + 8*i)) m_base[i] = mrg(m_base[i], d, be);
      if (a == 8'(8'h20 + 8*i)) m_lim[i]  = mrg(m_lim[i],  d, be);
    end
    if (a == 8'h3C && be[1]) m_pf = d[9:8];
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(req, $sformatf("read @%h", a), cfg_rdata, exp_rd(a));
  endtask

  task automatic dec_chk(input string req, input logic [31:0] a);
    logic ec; logic [0:0] ei; logic ep;
    mem_addr = a;
    #1;
    ec = 1'b0; ei = 1'b0; ep = 1'b0;
    for (int i = 1; i >= 0; i--) begin
      if (((m_base[i] != 0) || (m_lim[i] != 0)) && (a >= m_base[i]) &&
          (a <= (m_lim[i] | 32'hFFF))) begin
        ec = 1'b1; ei = 1'(i); ep = m_pf[i];
      end
    end
    chk(req, $sformatf("claim @%h", a), {31'd0, win_claim}, {31'd0, ec});
    chk(req, $sformatf("idx @%h", a), {31'd0, win_idx}, {31'd0, ei});
    chk(req, $sformatf("prefetch @%h", a), {31'd0, win_prefetch}, {31'd0, ep});
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < 'h60; p++) begin
      dec_chk(req, 32'(p) << 12);
      dec_chk(req, (32'(p) << 12) | 32'hFFF);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_wdata = 0; cfg_be = 0;
    mem_addr = 0;
    for (int i = 0; i < 2; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    m_pf = 0;
    repeat (3) @(negedge clk);
    chk("R1", "rdata after reset", cfg_rdata, 32'd0);
    rst = 1'b0;

    // R1 / R4: reset state, disabled windows do not claim page zero
    for (int a = 'h1C; a <= 'h3C; a += 4) rd_chk("R1", 8'(a));
    dec_chk("R4", 32'h0000_0000);
    dec_chk("R4", 32'h0000_0800);
    dec_chk("R4", 32'h0000_0FFF);

    // R2 / R3: writable bits and zero low bits
    wr(8'h1C, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3", 8'h1C);
    chk("R3", "base0 literal", cfg_rdata, 32'hFFFF_F000);
    wr(8'h1C, 32'h0, 4'hF);
    wr(8'h20, 32'h1234_5678, 4'b0101);
    rd_chk("R2", 8'h20);
    chk("R2", "limit0 byte enables", cfg_rdata, 32'h0034_0000);
    wr(8'h20, 32'hABCD_EFFF, 4'b1010);
    rd_chk("R2", 8'h20);
    wr(8'h20, 32'h0, 4'hF);

    // R8: unmapped writes and reads
    wr(8'h24, 32'h0007_7000, 4'hF);
    wr(8'h18, 32'hFFFF_FFFF, 4'hF);
    wr(8'h40, 32'hFFFF_FFFF, 4'hF);
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    for (int a = 0; a < 'h100; a += 4) rd_chk("R8", 8'(a));
    wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R8", 8'h3C);
    chk("R8", "ctl other bits zero", cfg_rdata, 32'h0000_0300);
    wr(8'h3C, 32'hFFFF_FFFF, 4'b1101);
    rd_chk("R7", 8'h3C);
    chk("R7", "ctl held without be1", cfg_rdata, 32'h0000_0300);

    // R5 / R6 / R7: overlapping windows, both prefetch settings
    wr(8'h1C, 32'h0001_0000, 4'hF);
    wr(8'h20, 32'h0003_0000, 4'hF);
    wr(8'h24, 32'h0002_0000, 4'hF);
    wr(8'h28, 32'h0005_0000, 4'hF);
    wr(8'h3C, 32'h0000_0200, 4'b0010);
    sweep("R5");
    dec_chk("R6", 32'h0002_0000);
    dec_chk("R5", 32'h0003_0FFF);
    dec_chk("R5", 32'h0005_0FFF);
    dec_chk("R5", 32'h0005_1000);
    wr(8'h3C, 32'h0000_0100, 4'b0010);
    sweep("R7");
    wr(8'h3C, 32'h0000_0300, 4'b0010);
    sweep("R6");

    // R5: inverted window 1 claims nothing
    wr(8'h24, 32'h0004_0000, 4'hF);
    wr(8'h28, 32'h0003_F000, 4'hF);
    sweep("R5");

    // R4: limit-only window 0, base-only window 1
    wr(8'h1C, 32'h0, 4'hF);
    wr(8'h20, 32'h0000_1000, 4'hF);
    wr(8'h24, 32'hFFFF_F000, 4'hF);
    wr(8'h28, 32'h0, 4'hF);
    sweep("R4");
    dec_chk("R4", 32'hFFFF_FFFF);

    // R5: top page of the address space
    wr(8'h28, 32'hFFFF_F000, 4'hF);
    dec_chk("R5", 32'hFFFF_FFFF);
    dec_chk("R5", 32'hFFFF_F000);
    dec_chk("R5", 32'hFFFF_EFFF);

    // R9: write, read and decode in the same cycle
    wr(8'h1C, 32'h0001_0000, 4'hF);
    wr(8'h20, 32'h0003_0000, 4'hF);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_addr = 8'h1C;
    cfg_wdata = 32'h0002_0000; cfg_be = 4'hF; mem_addr = 32'h0001_8000;
    #1;
    chk("R9", "claim before edge", {31'd0, win_claim}, 32'd1);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    chk("R9", "read returns old base", cfg_rdata, 32'h0001_0000);
    m_base[0] = 32'h0002_0000;
    dec_chk("R9", 32'h0001_8000);
    dec_chk("R9", 32'h0002_0000);
    repeat (2) @(negedge clk);
    chk("R9", "rdata holds", cfg_rdata, 32'h0001_0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule